// File: doc/BRIEF.md
# Banked Clock Fanout Controller

This block takes two candidate reference clocks, picks one, and spreads the chosen clock over sixteen output lines arranged as four banks of four. Each bank has its own control pair. A rate select chooses whether the bank runs at the reference frequency or at half of it. A bank enable turns the bank's clock on, or holds its lines low. Every line in a bank comes from one internal bank clock, so the four lines of a bank always match.

Enable and rate changes may arrive at any moment, with no relation to the reference clock. Each bank applies them through level-sensitive latches that are open only while the clocks they affect are low. As a result, no line ever shows a clipped high or low pulse. One active-low master input does two jobs. It holds every halving flip-flop cleared, and it releases all sixteen lines to high impedance. When it rises again, every halved bank starts from low and goes high together on the next reference rising edge.

Top module: `fanout_top`

## Requirements
- R1: With `refSel` = 1 the banks are clocked from `clkRefB`; with `refSel` = 0 from `clkRefA`. `refSel` is changed only while `resetN` is low.
- R2: With `divFull[b]` = 1 and bank b enabled, the bank's lines rise and fall together with the selected reference, with the same high and low durations.
- R3: With `divFull[b]` = 0 and bank b enabled, the bank runs at half the reference frequency. It is high for one whole reference period and low for the next, and it changes state only on reference rising edges.
- R4: With `bankEn[b]` = 0 the four lines of bank b are actively driven to 0, not left floating. Other banks are unaffected.
- R5: While `resetN` = 0 all sixteen lines are high impedance, whatever `bankEn` and `divFull` hold, and every halving flip-flop is held at 0.
- R6: Bank b drives `clkOut[4b+3:4b]`, and those four lines carry identical values at all times.
- R7: A change of `bankEn[b]` at any instant takes effect only while bank b's clock is low. No high or low pulse on the bank is shorter than its normal width.
- R8: A change of `divFull[b]` at any instant takes effect only while both the selected reference and the bank's halved clock are low. Every high pulse lasts either one reference high phase or one full reference period, and no low pulse is shorter than one reference low phase.
- R9: When `resetN` rises during a reference low phase, the enabled lines are first driven low. Every enabled halved bank then goes high on the first reference rising edge, so all halved banks are in phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkRefA | input | 1 | Reference clock used when `refSel` is 0 |
| clkRefB | input | 1 | Reference clock used when `refSel` is 1 |
| refSel | input | 1 | Reference clock select |
| resetN | input | 1 | Active-low master reset and output enable |
| divFull | input | NUM_BANKS | Per-bank rate select: 1 full rate, 0 half rate |
| bankEn | input | NUM_BANKS | Per-bank enable: 1 clock runs, 0 lines driven low |
| clkOut | output | NUM_BANKS*LINES_PER_BANK | Tristate clock lines, bank b on bits 4b+3..4b |

## Verification
The hardest case to reach from the ports is a control change that lands just after a bank's clock has gone high. Examples are a disable arriving while a halved bank is in its long high phase, or a rate change arriving while the halving flip-flop is high. Only there could a badly timed gate clip a pulse. The stimulus toggles one enable, and later one rate select, twelve times inside a single long observation window. The spacing between toggles grows by 0.7 ns on each step, which does not divide the 4 ns reference period, so the changes sweep across every phase of the full-rate and the halved clock. The monitor measures every complete high and low run in that window against the allowed widths.

// File: rtl/fanout_pkg.sv
`timescale 1ns/10ps
package fanout_pkg;

  // Per-bank strobes handed from the control side to the datapath.
  typedef struct packed {
    logic fullRate;  // latched rate choice: 1 = reference rate, 0 = halved
    logic halfClk;   // bank's own halved clock
    logic gateOpen;  // latched enable, only changes while the bank clock is low
  } bankStrobe_t;

endpackage

// File: rtl/fanout_ctrl.sv
`timescale 1ns/10ps
module fanout_ctrl
  import fanout_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic                  clkRefA,
  input  logic                  clkRefB,
  input  logic                  refSel,
  input  logic                  resetN,
  input  logic [NB-1:0]         divFull,
  input  logic [NB-1:0]         bankEn,
  output logic                  selClk,
  output bankStrobe_t [NB-1:0]  strobes
);

  // Two-way reference select; the select is only moved while resetN is low.
  assign selClk = refSel ? clkRefB : clkRefA;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic halfQ;
    logic rateLat;
    logic gateLat;
    logic rawClk;

    // Halving flip-flop, held cleared by the master reset.
    always_ff @(posedge selClk or negedge resetN) begin
      if (!resetN) halfQ <= 1'b0;
      else         halfQ <= ~halfQ;
    end

    // Rate choice passes only while both candidate clocks are low,
    // so the bank clock mux never switches on a high input.
    always_latch begin
      if (!selClk && !halfQ) rateLat = divFull[b];
    end

    assign rawClk = rateLat ? selClk : halfQ;

    // Enable passes only while the chosen bank clock is low.
    always_latch begin
      if (!resetN)      gateLat = 1'b0;
      else if (!rawClk) gateLat = bankEn[b];
    end

    assign strobes[b] = '{fullRate: rateLat, halfClk: halfQ, gateOpen: gateLat};
  end

endmodule

// File: rtl/fanout_dp.sv
`timescale 1ns/10ps
module fanout_dp
  import fanout_pkg::*;
#(
  parameter int NB  = 4,
  parameter int LPB = 4
) (
  input  logic                  selClk,
  input  bankStrobe_t [NB-1:0]  strobes,
  output logic [NB*LPB-1:0]     fanLines
);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic bankClk;
    logic gatedClk;

    assign bankClk  = strobes[b].fullRate ? selClk : strobes[b].halfClk;
    assign gatedClk = bankClk & strobes[b].gateOpen;

    // One bank clock feeds all lines of the bank.
    assign fanLines[b*LPB +: LPB] = {LPB{gatedClk}};
  end

endmodule

// File: rtl/fanout_top.sv
`timescale 1ns/10ps
module fanout_top
  import fanout_pkg::*;
#(
  parameter int NUM_BANKS      = 4,
  parameter int LINES_PER_BANK = 4
) (
  input  logic                                clkRefA,
  input  logic                                clkRefB,
  input  logic                                refSel,
  input  logic                                resetN,
  input  logic [NUM_BANKS-1:0]                divFull,
  input  logic [NUM_BANKS-1:0]                bankEn,
  output wire  [NUM_BANKS*LINES_PER_BANK-1:0] clkOut
);

  localparam int NUM_LINES = NUM_BANKS * LINES_PER_BANK;

  logic                        selClk;
  bankStrobe_t [NUM_BANKS-1:0] strobes;
  logic [NUM_LINES-1:0]        fanLines;

  fanout_ctrl #(.NB(NUM_BANKS)) u_ctrl (
    .clkRefA (clkRefA),
    .clkRefB (clkRefB),
    .refSel  (refSel),
    .resetN  (resetN),
    .divFull (divFull),
    .bankEn  (bankEn),
    .selClk  (selClk),
    .strobes (strobes)
  );

  fanout_dp #(.NB(NUM_BANKS), .LPB(LINES_PER_BANK)) u_dp (
    .selClk   (selClk),
    .strobes  (strobes),
    .fanLines (fanLines)
  );

  // Master input low releases every line.
  assign clkOut = resetN ? fanLines : {NUM_LINES{1'bz}};

endmodule

// File: rtl/fanout_chk.sv
`timescale 1ns/10ps
module fanout_chk
  import fanout_pkg::*;
#(
  parameter int NB  = 4,
  parameter int LPB = 4
) (
  input  logic                  clkRefA,
  input  logic                  clkRefB,
  input  logic                  refSel,
  input  logic                  resetN,
  input  logic [NB-1:0]         divFull,
  input  logic [NB-1:0]         bankEn,
  input  logic [NB*LPB-1:0]     fanLines,
  input  bankStrobe_t [NB-1:0]  strobes
);

  logic chkClk;
  assign chkClk = refSel ? clkRefB : clkRefA;

  // Edges seen since reset release, saturating; keeps $past inside that span.
  logic [2:0] settle;
  logic       settled;
  always_ff @(posedge chkClk or negedge resetN) begin
    if (!resetN)              settle <= 3'd0;
    else if (settle != 3'd7)  settle <= settle + 3'd1;
  end
  assign settled = (settle >= 3'd5);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic lineAtFall;
    always_ff @(negedge chkClk) lineAtFall <= fanLines[b*LPB];

    // R5
    always @(negedge chkClk) begin
      if (!resetN) begin
        div_clear_chk: assert (!strobes[b].halfClk && !strobes[b].gateOpen)
          else $error("R5 halving stage or gate not cleared in bank %0d", b);
      end
    end

    // R4
    bank_low_chk: assert property (@(posedge chkClk) disable iff (!resetN)
      (settled && !bankEn[b] && $past(!bankEn[b]) && $past(!bankEn[b], 2) &&
       $past(!bankEn[b], 3)) |-> !fanLines[b*LPB])
      else $error("R4 disabled bank %0d not low", b);

    // R3
    half_toggle_chk: assert property (@(posedge chkClk) disable iff (!resetN)
      (settled && !strobes[b].fullRate && $past(!strobes[b].fullRate) &&
       !divFull[b] && $past(!divFull[b], 3) &&
       bankEn[b] && $past(bankEn[b]) && $past(bankEn[b], 2) && $past(bankEn[b], 3))
      |-> (fanLines[b*LPB] != $past(fanLines[b*LPB])))
      else $error("R3 halved bank %0d did not alternate", b);

    // R7
    no_late_rise_chk: assert property (@(posedge chkClk) disable iff (!resetN)
      (settled && fanLines[b*LPB]) |-> lineAtFall)
      else $error("R7 bank %0d rose during a reference low phase", b);
  end

endmodule

bind fanout_top fanout_chk #(.NB(NUM_BANKS), .LPB(LINES_PER_BANK)) chk (
  .clkRefA  (clkRefA),
  .clkRefB  (clkRefB),
  .refSel   (refSel),
  .resetN   (resetN),
  .divFull  (divFull),
  .bankEn   (bankEn),
  .fanLines (fanLines),
  .strobes  (strobes)
);

// File: tb/tb_fanout_top.sv
`timescale 1ns/10ps
module tb_fanout_top;

  localparam int NB  = 4;
  localparam int LPB = 4;
  localparam int NL  = NB * LPB;

  logic          clkRefA = 1'b0;
  logic          clkRefB = 1'b0;
  logic          refSel;
  logic          resetN;
  logic [NB-1:0] divFull;
  logic [NB-1:0] bankEn;
  wire  [NL-1:0] clkOut;

  always #2 clkRefA = ~clkRefA;  // 250 MHz
  always #3 clkRefB = ~clkRefB;

  // Pull-ups make a released line read 1, a driven-low line read 0.
  for (genvar g = 0; g < NL; g++) begin : g_pull
    pullup (clkOut[g]);
  end

  fanout_top #(.NUM_BANKS(NB), .LINES_PER_BANK(LPB)) dut (
    .clkRefA (clkRefA),
    .clkRefB (clkRefB),
    .refSel  (refSel),
    .resetN  (resetN),
    .divFull (divFull),
    .bankEn  (bankEn),
    .clkOut  (clkOut)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Sample tick at every x.5 ns, away from all reference edges.
  event tick;
  initial begin
    #0.5;
    forever begin
      -> tick;
      #1;
    end
  end

  typedef struct {
    string req;
    int    bank;
    int    samples;
    bit    isConst;
    bit    level;
    int    minHigh;
    int    maxHigh;
    int    minLow;
    int    maxLow;   // 0: not bounded
  } item_t;

  item_t expQ[$];

  task automatic push_clock(input string req, input int bank, input int samples,
                            input int minH, input int maxH, input int minL, input int maxL);
    item_t it;
    it = '{req: req, bank: bank, samples: samples, isConst: 1'b0, level: 1'b0,
           minHigh: minH, maxHigh: maxH, minLow: minL, maxLow: maxL};
    expQ.push_back(it);
  endtask

  task automatic push_const(input string req, input int bank, input int samples, input bit level);
    item_t it;
    it = '{req: req, bank: bank, samples: samples, isConst: 1'b1, level: level,
           minHigh: 0, maxHigh: 0, minLow: 0, maxLow: 0};
    expQ.push_back(it);
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(tick);
  endtask

  // Monitor: measures each queued expectation against the bank's lines.
  task automatic measure(input item_t it);
    logic [LPB-1:0] v;
    bit prev = 1'b0;
    int run = 0, trans = 0, rises = 0, split = 0, bad = 0;
    int minH = 1000, maxH = 0, minL = 1000, maxL = 0;
    bit ok;
    for (int i = 0; i < it.samples; i++) begin
      @(tick);
      v = clkOut[it.bank*LPB +: LPB];
      if (v != '0 && v != '1) split++;
      if (it.isConst && v[0] != it.level) bad++;
      if (i == 0) begin
        prev = v[0];
        run  = 1;
      end else if (v[0] == prev) begin
        run++;
      end else begin
        if (trans > 0) begin
          if (prev) begin
            if (run < minH) minH = run;
            if (run > maxH) maxH = run;
          end else begin
            if (run < minL) minL = run;
            if (run > maxL) maxL = run;
          end
        end
        trans++;
        if (v[0]) rises++;
        prev = v[0];
        run  = 1;
      end
    end
    // R6: the four lines of the bank agree on every sample
    check(split == 0, "R6", $sformatf("bank %0d split samples", it.bank), split, 0);
    if (it.isConst) begin
      check(bad == 0, it.req,
            $sformatf("bank %0d samples off level %0d", it.bank, it.level), bad, 0);
    end else begin
      ok = (rises >= 2) && (minH >= it.minHigh) && (maxH <= it.maxHigh) &&
           (minL >= it.minLow) && (it.maxLow == 0 || maxL <= it.maxLow);
      checks++;
      if (!ok) begin
        fails++;
        $display("FAIL %s bank %0d: actual high %0d..%0d low %0d..%0d rises %0d, expected high %0d..%0d low %0d..%0d rises>=2",
                 it.req, it.bank, minH, maxH, minL, maxL, rises,
                 it.minHigh, it.maxHigh, it.minLow, it.maxLow);
      end
    end
  endtask

  initial begin
    forever begin
      while (expQ.size() == 0) @(tick);
      measure(expQ[0]);
      void'(expQ.pop_front());
    end
  end

  // Driver
  initial begin
    refSel  = 1'b0;
    resetN  = 1'b0;
    divFull = 4'h0;
    bankEn  = 4'hF;
    #20;

    // R5: under reset every line floats (reads 1 through the pull-up)
    for (int b = 0; b < NB; b++) push_const("R5", b, 16, 1'b1);
    drain();
    bankEn  = 4'h0;
    divFull = 4'hF;
    #8;
    for (int b = 0; b < NB; b++) push_const("R5", b, 16, 1'b1);
    drain();

    // R9: release in a low phase, all halved banks start together
    bankEn  = 4'hF;
    divFull = 4'h0;
    @(negedge clkRefA);
    #0.25 resetN = 1'b1;
    #0.5;
    check(clkOut == 16'h0000, "R9", "lines just after release", clkOut, 16'h0000);
    @(posedge clkRefA);
    #0.5;
    check(clkOut == 16'hFFFF, "R9", "lines after first reference rise", clkOut, 16'hFFFF);
    @(posedge clkRefA);
    #0.5;
    check(clkOut == 16'h0000, "R3", "lines after second reference rise", clkOut, 16'h0000);

    // R3: all banks halved, 4 ns high / 4 ns low
    for (int b = 0; b < NB; b++) push_clock("R3", b, 40, 4, 4, 4, 4);
    drain();

    // R2: all banks at reference rate, 2 ns high / 2 ns low
    divFull = 4'hF;
    #20;
    for (int b = 0; b < NB; b++) push_clock("R2", b, 40, 2, 2, 2, 2);
    drain();

    // R2/R3 mixed: banks 0,2 full, banks 1,3 halved
    divFull = 4'b0101;
    #20;
    push_clock("R2", 0, 40, 2, 2, 2, 2);
    push_clock("R3", 1, 40, 4, 4, 4, 4);
    push_clock("R2", 2, 40, 2, 2, 2, 2);
    push_clock("R3", 3, 40, 4, 4, 4, 4);
    drain();

    // R4: banks 1,3 disabled and driven 0, banks 0,2 keep running
    bankEn = 4'b0101;
    #20;
    push_const("R4", 1, 30, 1'b0);
    push_const("R4", 3, 30, 1'b0);
    push_clock("R4", 0, 40, 2, 2, 2, 2);
    push_clock("R4", 2, 40, 2, 2, 2, 2);
    drain();

    // R7: enable toggled at sweeping phases on a full-rate bank
    bankEn  = 4'hF;
    divFull = 4'hF;
    #20;
    push_clock("R7", 0, 200, 2, 2, 2, 0);
    for (int i = 0; i < 12; i++) begin
      #(5.3 + 0.7 * i);
      bankEn[0] = ~bankEn[0];
    end
    drain();

    // R7: same on a halved bank
    divFull = 4'h0;
    #20;
    push_clock("R7", 1, 200, 4, 4, 4, 0);
    for (int i = 0; i < 12; i++) begin
      #(5.3 + 0.7 * i);
      bankEn[1] = ~bankEn[1];
    end
    drain();

    // R8: rate select toggled at sweeping phases
    #20;
    push_clock("R8", 2, 200, 2, 4, 2, 0);
    for (int i = 0; i < 12; i++) begin
      #(4.9 + 0.7 * i);
      divFull[2] = ~divFull[2];
    end
    drain();

    // R1: switch to the second reference under reset, 3 ns phases
    resetN = 1'b0;
    #8;
    refSel  = 1'b1;
    divFull = 4'b1101;
    bankEn  = 4'hF;
    #12;
    @(negedge clkRefB);
    #0.25 resetN = 1'b1;
    #30;
    push_clock("R1", 0, 60, 3, 3, 3, 3);
    push_clock("R1", 1, 60, 6, 6, 6, 6);
    drain();

    // R5: reset asserted while running floats every line again
    resetN = 1'b0;
    #2;
    for (int b = 0; b < NB; b++) push_const("R5", b, 16, 1'b1);
    drain();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  // Watchdog
  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule